// File: doc/BRIEF.md
# I2C Streaming-Read Target Port

This block is an I2C target that connects an 8-bit parallel input port and an 8-bit parallel output port to a two-wire bus. A controller that addresses the block for writing has every data byte latched onto the output port, and each byte is acknowledged. A controller that addresses it for reading receives the current input-port value. If the controller acknowledges that byte, the block samples the input port again and keeps sending. A controller can therefore poll the port continuously without issuing a new START and address for each byte.

Both bus lines reach the block as raw samples and pass through synchronizers into the system clock domain. The block drives SDA only through an open-drain enable. Bus-condition recognition is a separate unit from the byte engine. A START seen at any moment aborts whatever the engine is doing and opens a new address phase. A STOP puts the engine back to idle, and from then on only the condition detector watches the bus.

Top module: `i2c_stream_port`

## Requirements
- R1: After reset the SDA pull-down enable is off and the output port reads 0x00.
- R2: A falling SDA while SCL is high (START) aborts any transfer in progress, releases SDA and begins a new 7-bit address phase.
- R3: A rising SDA while SCL is high (STOP) returns the engine to idle and releases SDA. Bus clocks that follow are ignored until the next START: nothing is acknowledged and the output port keeps its value.
- R4: The first byte after START carries the 7-bit address MSB first, followed by a direction bit (1 = read, 0 = write). On a match with the configured address (default 0x2A), SDA is pulled low during the ninth clock. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R5: In a write transfer, each data byte is received MSB first, copied to the output port, and acknowledged in its ninth clock.
- R6: In a read transfer, the input port is sampled once at the start of each byte and shifted out MSB first. A change on the input port during the byte does not alter the bits being sent.
- R7: When the controller pulls SDA low in the ninth clock of a read byte, the block sends another byte built from a fresh input-port sample, with no new address phase.
- R8: When the controller leaves SDA high in the ninth clock of a read byte, the block stops driving SDA and ignores bus clocks until START or STOP.
- R9: Outside of START/STOP handling, the block changes its SDA drive only while SCL is low. It releases its own acknowledge on the SCL falling edge that ends the ninth clock.
- R10: A START that comes where the first bit of a new write byte is being clocked cancels that byte (the output port is not updated), and a fresh address phase follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw sample of the SCL line |
| sda_i | input | 1 | Raw sample of the SDA line |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| port_in_i | input | 8 | Parallel value returned on reads |
| port_out_o | output | 8 | Latest byte written by the controller |

## Verification
The assertions assume a bus whose SCL phases each last many system clocks, so that a synchronized edge reaches the engine well before the opposite edge arrives. They also assume that the controller moves SDA only while SCL is low, except when it deliberately forms a START or STOP. The stimulus holds every SCL phase for twenty system clocks, changes data in the middle of the low phase, and forms START and STOP only when the block has released SDA. That last point matters because a target holding SDA low would mask the controller's edge. The bus is modelled as a wired-AND of the controller's drive and the block's pull-down.

// File: rtl/i2c_stream_pkg.sv
package i2c_stream_pkg;

  // Byte engine phases
  typedef enum logic [2:0] {
    ST_IDLE,      // asleep, only the condition detector is watching
    ST_ADDR,      // shifting in address + direction
    ST_ADDR_ACK,  // driving acknowledge for own address
    ST_WR_DATA,   // shifting in a write byte
    ST_WR_ACK,    // driving acknowledge for a write byte
    ST_RD_DATA,   // shifting out a read byte
    ST_RD_ACK,    // controller's acknowledge slot
    ST_HOLD       // not addressed or read ended: ignore until START/STOP
  } eng_state_e;

  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;
  localparam int unsigned N_LINES  = 2;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      logic              prev_q;

      // idle bus level is high, so reset the chain high to avoid false edges
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
          prev_q  <= 1'b1;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
          prev_q  <= chain_q[STAGES-1];
        end
      end

      assign lvl_o[g]  = chain_q[STAGES-1];
      assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
      assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
    end
  endgenerate

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic scl_rise,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_o,
  output logic stop_o
);

  logic scl_steady_hi;
  logic start_d, stop_d;
  logic start_q, stop_q;

  // SCL must already have been high before this cycle
  assign scl_steady_hi = scl_lvl & ~scl_rise;

  always_comb begin
    start_d = sda_fall & scl_steady_hi;
    stop_d  = sda_rise & scl_steady_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

  assign start_o = start_q;
  assign stop_o  = stop_q;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_stream_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 7,
  parameter int unsigned        DATA_W   = 8,
  parameter logic [ADDR_W-1:0]  DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [DATA_W-1:0] port_in,
  output logic              sda_oe,
  output logic [DATA_W-1:0] port_out,
  output logic              busy
);

  localparam int unsigned       CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(DATA_W - 1);

  eng_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic              oe_q, oe_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              shift_in_en;
  logic              addr_hit;

  assign shift_in_en = scl_rise && (cnt_q != CNT_FULL);
  assign addr_hit    = (sh_q[DATA_W-1 -: ADDR_W] == DEV_ADDR);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    out_d   = out_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    mack_d  = mack_q;

    if (start_p) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_p) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_HOLD: ;

        ST_ADDR: begin
          if (shift_in_en) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (addr_hit) begin
              rw_d    = sh_q[0];
              oe_d    = 1'b1;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_HOLD;
            end
          end
        end

        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              sh_d    = port_in;
              oe_d    = ~port_in[DATA_W-1];
              state_d = ST_RD_DATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WR_DATA;
            end
          end
        end

        ST_WR_DATA: begin
          if (shift_in_en) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            out_d   = sh_q;
            oe_d    = 1'b1;
            state_d = ST_WR_ACK;
          end
        end

        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WR_DATA;
          end
        end

        ST_RD_DATA: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              oe_d    = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              sh_d  = {sh_q[DATA_W-2:0], 1'b0};
              oe_d  = ~sh_q[DATA_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end

        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d    = port_in;
              oe_d    = ~port_in[DATA_W-1];
              cnt_d   = '0;
              state_d = ST_RD_DATA;
            end else begin
              state_d = ST_HOLD;
            end
          end
        end

        default: state_d = ST_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      out_q   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe   = oe_q;
  assign port_out = out_q;
  assign busy     = (state_q != ST_IDLE);

endmodule

// File: rtl/i2c_stream_port.sv
module i2c_stream_port
  import i2c_stream_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 7,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h2A,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [DATA_W-1:0] port_in_i,
  output logic [DATA_W-1:0] port_out_o
);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [N_LINES-1:0] raw, lvl, rise, fall;
  logic               scl_lvl;
  logic               start_p, stop_p;
  logic               busy;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw[LINE_SCL] = scl_i;
  assign raw[LINE_SDA] = sda_i;

  i2c_line_sync #(
    .LINES  (N_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .raw_i  (raw),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign scl_lvl = lvl[LINE_SCL];

  i2c_cond_detect u_cond (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .scl_lvl  (scl_lvl),
    .scl_rise (rise[LINE_SCL]),
    .sda_rise (rise[LINE_SDA]),
    .sda_fall (fall[LINE_SDA]),
    .start_o  (start_p),
    .stop_o   (stop_p)
  );

  i2c_byte_engine #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .scl_rise (rise[LINE_SCL]),
    .scl_fall (fall[LINE_SCL]),
    .sda_lvl  (lvl[LINE_SDA]),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .port_in  (port_in_i),
    .sda_oe   (sda_oe_o),
    .port_out (port_out_o),
    .busy     (busy)
  );

endmodule

// File: rtl/i2c_stream_port_chk.sv
module i2c_stream_port_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic start_p,
  input logic stop_p,
  input logic sda_oe,
  input logic busy
);

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !sda_oe);                                                 // R2

  AST_START_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> busy);                                                    // R2

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_oe);                                                  // R3

  AST_STOP_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !busy);                                                    // R3

  AST_DRIVE_ONLY_ENGAGED: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy);                                                     // R4

  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);                                          // R9

  AST_RELEASE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !$past(start_p) && !$past(stop_p)) |-> !scl_lvl);   // R9

endmodule

bind i2c_stream_port i2c_stream_port_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_lvl (scl_lvl),
  .start_p (start_p),
  .stop_p  (stop_p),
  .sda_oe  (sda_oe_o),
  .busy    (busy)
);

// File: tb/i2c_stream_port_tb.sv
`timescale 1ns/1ps
module i2c_stream_port_tb;

  localparam int        Q    = 10;      // system clocks per quarter SCL period
  localparam logic [6:0] ADDR = 7'h2A;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl;
  logic       sda_ctl;
  logic [7:0] pin;
  logic       oe;
  logic [7:0] pout;
  wire        sda_line = sda_ctl & ~oe;

  always #4 clk = ~clk;   // 125 MHz

  i2c_stream_port u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (oe),
    .port_in_i  (pin),
    .port_out_o (pout)
  );

  // ---------------- scoreboard ----------------
  typedef struct {
    string       req;
    logic [15:0] val;
  } item_t;

  item_t exp_q[$];
  item_t obs_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  event  obs_ev;
  item_t mon_o, mon_e;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(input string req, input logic [15:0] v);
    item_t it;
    it.req = req; it.val = v;
    exp_q.push_back(it);
  endtask

  task automatic observe(input string req, input logic [15:0] v);
    item_t it;
    it.req = req; it.val = v;
    obs_q.push_back(it);
    -> obs_ev;
  endtask

  task automatic check(input string req, input logic [15:0] e, input logic [15:0] a);
    expect_val(req, e);
    observe(req, a);
  endtask

  initial begin
    forever begin
      @(obs_ev);
      while (obs_q.size() != 0) begin
        mon_o = obs_q.pop_front();
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s: actual=%h expected=<none queued>", mon_o.req, mon_o.val);
        end else begin
          mon_e = exp_q.pop_front();
          if (mon_o.val !== mon_e.val) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", mon_e.req, mon_o.val, mon_e.val);
          end
        end
      end
    end
  end

  // ---------------- R9 watcher: drive may not move while SCL is high ----------------
  int   r9_viol = 0;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && scl === 1'b1 && oe !== prev_oe) r9_viol++;
    prev_oe = oe;
  end

  // ---------------- bus driver ----------------
  task automatic clk_bit(input logic b, output logic seen);
    tick(Q); sda_ctl = b;
    tick(Q); scl = 1'b1;
    tick(Q); seen = sda_line;
    tick(Q); scl = 1'b0;
  endtask

  task automatic bus_start();
    sda_ctl = 1'b1; tick(Q);
    scl = 1'b1;     tick(Q);
    sda_ctl = 1'b0; tick(Q);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_ctl = 1'b0; tick(Q);
    scl = 1'b1;     tick(Q);
    sda_ctl = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_seen);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack_seen);
  endtask

  // reads one byte, changes the input port mid-byte to nxt, answers with do_ack
  task automatic read_check(input string req, input logic do_ack, input logic [7:0] nxt);
    logic [7:0] got;
    logic s;
    expect_val(req, {8'h00, pin});
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      got[i] = s;
      if (i == 5) pin = nxt;
    end
    clk_bit(!do_ack, s);
    observe(req, {8'h00, got});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    tick(150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    logic a;
    logic s;
    rst_n = 1'b0; scl = 1'b1; sda_ctl = 1'b1; pin = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // R1: reset state
    check("R1", 16'(1'b0), 16'(oe));
    check("R1", 16'h00, 16'(pout));

    // R4/R5: addressed write of two bytes
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    check("R4", 16'(1'b0), 16'(a));
    send_byte(8'hA5, a);
    check("R5", 16'(1'b0), 16'(a));
    check("R5", 16'hA5, 16'(pout));
    tick(Q);
    check("R9", 16'(1'b0), 16'(oe));   // own ACK released after SCL fell
    send_byte(8'h3C, a);
    check("R5", 16'(1'b0), 16'(a));
    check("R5", 16'h3C, 16'(pout));
    bus_stop();
    tick(Q);
    check("R3", 16'(1'b0), 16'(oe));

    // R4: foreign address is not acknowledged, following byte ignored
    bus_start();
    send_byte({7'h15, 1'b0}, a);
    check("R4", 16'(1'b1), 16'(a));
    send_byte(8'h00, a);
    check("R4", 16'(1'b1), 16'(a));
    check("R4", 16'h3C, 16'(pout));
    bus_stop();

    // R6/R7/R8: streaming read
    pin = 8'h96;
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    check("R4", 16'(1'b0), 16'(a));
    read_check("R6", 1'b1, 8'h5A);   // mid-byte change must not leak in
    read_check("R7", 1'b1, 8'hC3);   // fresh sample after controller ACK
    read_check("R7", 1'b0, 8'h00);   // NACK ends the read
    pin = 8'h00;                      // would pull SDA low if still sending
    expect_val("R8", 16'h00FF);
    begin
      logic [7:0] g;
      for (int i = 7; i >= 0; i--) begin
        clk_bit(1'b1, s);
        g[i] = s;
      end
      clk_bit(1'b1, s);
      observe("R8", {8'h00, g});
    end
    bus_stop();

    // R10: START during first bit of a new write byte
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h11, a);
    check("R5", 16'h11, 16'(pout));
    bus_start();                      // SCL rises with SDA high, then SDA falls
    send_byte({ADDR, 1'b1}, a);
    check("R10", 16'(1'b0), 16'(a));
    check("R10", 16'h11, 16'(pout));
    pin = 8'hE7;
    read_check("R10", 1'b0, 8'hE7);
    bus_stop();

    // R2: START aborts a read in mid-byte
    pin = 8'hFF;
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
    bus_start();
    tick(Q);
    check("R2", 16'(1'b0), 16'(oe));
    send_byte({ADDR, 1'b0}, a);
    check("R2", 16'(1'b0), 16'(a));
    send_byte(8'h77, a);
    check("R2", 16'h77, 16'(pout));

    // R3: STOP mid-write, later clocks ignored
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_stop();
    sda_ctl = 1'b1; tick(Q); scl = 1'b0;
    send_byte(8'h00, a);
    check("R3", 16'(1'b1), 16'(a));
    check("R3", 16'h77, 16'(pout));
    scl = 1'b1; tick(Q);

    // R9: drive never moved while SCL was high
    check("R9", 16'd0, 16'(r9_viol));

    tick(4);
    finished = 1;
    finish_run();
  end

endmodule